// File: doc/BRIEF.md
# Machine ISA Extension Register

This block holds the machine-mode register, at CSR address 0x301, that tells software which single-letter ISA extensions the core supports and lets it switch some of them off. The top two bits of the register report the native register width. Each of the 26 letters A to Z has a bit at the position of its place in the alphabet. Software reads the register through a simple CSR port and writes it through the same port. The block exports one active flag per letter, so the core's decoder can reject instructions that belong to a disabled extension. It also exports a flag that says whether 32-bit instruction alignment is required.

Parameters set the register width (32 or 64), which extensions the core implements, and which of those software may turn off. A further parameter removes the register entirely; it then reads as all zeros. Writes are legalized before they are stored. A write that would leave the floating-point letters in an inconsistent state keeps the offending bit at its old value, and the rest of the same write still lands. The G letter has no storage of its own. It is formed from A, M, F and D.

Top module: `isa_ext_reg`

## Requirements
- R1: After a synchronous active-low reset, each implemented letter bit is 1 and every other letter bit is 0. The I bit (position 8) is always 1. With the default configuration, a read at 0x301 returns 0x4015116D.
- R2: Read data bits XLEN-1:XLEN-2 hold the width code: 2'b01 for XLEN 32 and 2'b10 for XLEN 64. Writes never change them.
- R3: A letter bit changes on a write only if that extension is implemented and marked mutable. All other letter bits, including I (8), S (18) when not mutable, and B (1) when not implemented, keep their value.
- R4: The G bit (position 6) reads as the AND of A (0), M (12), F (5) and D (3). A value written to position 6 has no effect.
- R5: If a write would give F (5) the value 0 while the resulting D (3) is 1, F keeps its previous value. The other fields of that write still update.
- R6: If a write would give Q (16) the value 1 while the resulting F or D is 0, Q keeps its previous value. The other fields of that write still update.
- R7: A write takes effect at the clock edge where csr_we is 1 and csr_addr is 0x301. With csr_we low, or at any other address, the state is unchanged.
- R8: Reads at any address other than 0x301 return zero. Bit positions 26 to XLEN-3 always read as zero.
- R9: When the register is configured as absent, reads return zero (including the width code), writes are ignored, and every active flag is 0.
- R10: ext_active reports the stored letter bits, with G derived as in R4. ialign32 is 1 exactly when the C bit (2) is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | CSR address of the access |
| csr_we | input | 1 | Write enable, sampled on the rising edge |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for csr_addr |
| ext_active | output | 26 | Per-letter active flag, bit n for letter n |
| ialign32 | output | 1 | 1 when compressed instructions are disabled |

## Verification
The bench targets the floating-point dependency rules. A design that resolved an illegal F or Q request by dropping the whole write would lose the A change made in the same write. A design that checked Q against the old F and D, instead of the resolved ones, would either accept Q while F and D stay clear or reject Q when F, D and Q are all set in one write. The bench writes all ones and then all zeros to catch bits that should be frozen but are stored: the non-mutable S, the unimplemented B, the forced I, and G and the width code. A second and a third instance check the 64-bit width code and the configuration where the register is absent, which must show zero even after a write of all ones.

// File: rtl/isa_ext_pkg.sv
// Package: shared constants for the ISA extension register.
// Assumes letter n of the alphabet lives at bit n of the register.
package isa_ext_pkg;
    localparam int          NUM_LETTERS  = 26;
    localparam logic [11:0] ISA_CSR_ADDR = 12'h301;

    localparam int LTR_A = 0;
    localparam int LTR_B = 1;
    localparam int LTR_C = 2;
    localparam int LTR_D = 3;
    localparam int LTR_F = 5;
    localparam int LTR_G = 6;
    localparam int LTR_I = 8;
    localparam int LTR_M = 12;
    localparam int LTR_Q = 16;

    // Width code placed in the top two bits.
    function automatic logic [1:0] width_code(input int w);
        return (w == 64) ? 2'b10 : 2'b01;
    endfunction
endpackage

// File: rtl/isa_ext_legalize.sv
// Module: isa_ext_legalize
// Forms the next letter state from the current state and a write request.
// Only bits in WR_MASK take request values. An illegal F or Q request
// keeps the old value of that bit alone. Assumes G is not in WR_MASK.
module isa_ext_legalize
    import isa_ext_pkg::*;
#(
    parameter logic [NUM_LETTERS-1:0] WR_MASK = '0
) (
    input  logic [NUM_LETTERS-1:0] cur_bits,
    input  logic [NUM_LETTERS-1:0] req_bits,
    output logic [NUM_LETTERS-1:0] nxt_bits
);
    logic [NUM_LETTERS-1:0] cand;

    // Merge request into mutable bits, then apply dependency rules.
    always_comb begin
        cand     = (cur_bits & ~WR_MASK) | (req_bits & WR_MASK);
        nxt_bits = cand;
        if (!cand[LTR_F] && cand[LTR_D]) begin
            nxt_bits[LTR_F] = cur_bits[LTR_F];
        end
        if (nxt_bits[LTR_Q] && !(nxt_bits[LTR_F] && nxt_bits[LTR_D])) begin
            nxt_bits[LTR_Q] = cur_bits[LTR_Q];
        end
    end
endmodule

// File: rtl/isa_ext_bit_cell.sv
// Module: isa_ext_bit_cell
// One letter bit. When STORE is set it is a flop with a reset value that
// loads d on load; otherwise it is the constant RST_VAL.
module isa_ext_bit_cell #(
    parameter bit RST_VAL = 1'b0,
    parameter bit STORE   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic d,
    output logic q
);
    generate
        if (STORE) begin : g_flop
            logic q_r;
            // Hold the bit, reload on an accepted write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_r <= RST_VAL;
                end else if (load) begin
                    q_r <= d;
                end
            end
            assign q = q_r;
        end else begin : g_const
            logic unused_in;
            assign unused_in = clk ^ rst_n ^ load ^ d;
            assign q = RST_VAL;
        end
    endgenerate
endmodule

// File: rtl/isa_ext_readback.sv
// Module: isa_ext_readback
// Formats read data: letter bits, derived G and the width code. Returns
// zero when the address misses or the register is absent.
module isa_ext_readback
    import isa_ext_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter bit REG_PRESENT = 1'b1
) (
    input  logic [NUM_LETTERS-1:0] bits,
    input  logic                   addr_hit,
    output logic [XLEN-1:0]        rdata
);
    // Assemble the read word.
    always_comb begin
        rdata = '0;
        if (REG_PRESENT && addr_hit) begin
            rdata[NUM_LETTERS-1:0] = bits;
            rdata[LTR_G]           = bits[LTR_A] & bits[LTR_M] & bits[LTR_F] & bits[LTR_D];
            rdata[XLEN-1 -: 2]     = width_code(XLEN);
        end
    end
endmodule

// File: rtl/isa_ext_reg.sv
// Module: isa_ext_reg
// Machine-mode ISA extension register at CSR 0x301. It stores one bit per
// letter and legalizes writes. It exports per-letter active flags and the
// alignment mode. Assumes privilege checks are done by the caller.
module isa_ext_reg
    import isa_ext_pkg::*;
#(
    parameter int                     XLEN         = 32,
    parameter logic [NUM_LETTERS-1:0] EXT_PRESENT  = 26'h15112D,
    parameter logic [NUM_LETTERS-1:0] EXT_WRITABLE = 26'h11102F,
    parameter bit                     REG_PRESENT  = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [11:0]            csr_addr,
    input  logic                   csr_we,
    input  logic [XLEN-1:0]        csr_wdata,
    output logic [XLEN-1:0]        csr_rdata,
    output logic [NUM_LETTERS-1:0] ext_active,
    output logic                   ialign32
);
    localparam logic [NUM_LETTERS-1:0] G_BIT     = NUM_LETTERS'(1) << LTR_G;
    localparam logic [NUM_LETTERS-1:0] I_BIT     = NUM_LETTERS'(1) << LTR_I;
    localparam logic [NUM_LETTERS-1:0] IMPL_MASK =
        REG_PRESENT ? ((EXT_PRESENT | I_BIT) & ~G_BIT) : '0;
    localparam logic [NUM_LETTERS-1:0] WR_MASK   = IMPL_MASK & EXT_WRITABLE & ~I_BIT;

    logic                   addr_hit;
    logic                   wr_hit;
    logic [NUM_LETTERS-1:0] ext_q;
    logic [NUM_LETTERS-1:0] ext_d;
    logic                   unused_wdata_hi;

    assign addr_hit        = (csr_addr == ISA_CSR_ADDR);
    assign wr_hit          = csr_we && addr_hit;
    assign unused_wdata_hi = ^csr_wdata[XLEN-1:NUM_LETTERS];

    isa_ext_legalize #(.WR_MASK(WR_MASK)) u_legal (
        .cur_bits (ext_q),
        .req_bits (csr_wdata[NUM_LETTERS-1:0]),
        .nxt_bits (ext_d)
    );

    generate
        for (genvar i = 0; i < NUM_LETTERS; i++) begin : g_letter
            isa_ext_bit_cell #(
                .RST_VAL (IMPL_MASK[i]),
                .STORE   (WR_MASK[i])
            ) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (wr_hit),
                .d     (ext_d[i]),
                .q     (ext_q[i])
            );
        end
    endgenerate

    isa_ext_readback #(.XLEN(XLEN), .REG_PRESENT(REG_PRESENT)) u_rd (
        .bits     (ext_q),
        .addr_hit (addr_hit),
        .rdata    (csr_rdata)
    );

    // Active flags: stored letters with G derived from A, M, F, D.
    always_comb begin
        ext_active        = ext_q;
        ext_active[LTR_G] = ext_q[LTR_A] & ext_q[LTR_M] & ext_q[LTR_F] & ext_q[LTR_D];
    end

    assign ialign32 = ~ext_q[LTR_C];
endmodule

// Module: isa_ext_reg_chk
// Property checks on the ISA extension register, bound to every instance.
module isa_ext_reg_chk
    import isa_ext_pkg::*;
#(
    parameter int                     XLEN        = 32,
    parameter bit                     REG_PRESENT = 1'b1,
    parameter logic [NUM_LETTERS-1:0] WR_MASK     = '0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [11:0]            csr_addr,
    input logic                   csr_we,
    input logic [XLEN-1:0]        csr_wdata,
    input logic [XLEN-1:0]        csr_rdata,
    input logic [NUM_LETTERS-1:0] ext_active,
    input logic                   ialign32,
    input logic [NUM_LETTERS-1:0] ext_q
);
    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_we && csr_addr == ISA_CSR_ADDR) |=> $stable(ext_q));

    assert_f_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == ISA_CSR_ADDR && !csr_wdata[LTR_F] &&
         (WR_MASK[LTR_D] ? csr_wdata[LTR_D] : ext_q[LTR_D]))
        |=> ext_q[LTR_F] == $past(ext_q[LTR_F]));

    assert_q_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_q[LTR_Q]) |-> (ext_q[LTR_F] && ext_q[LTR_D]));

    assert_g_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ISA_CSR_ADDR) |->
        csr_rdata[LTR_G] == (ext_q[LTR_A] & ext_q[LTR_M] & ext_q[LTR_F] & ext_q[LTR_D]));

    assert_other_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr != ISA_CSR_ADDR) |-> csr_rdata == '0);

    assert_ialign_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ialign32 == !ext_active[LTR_C]);

    generate
        if (REG_PRESENT) begin : g_on
            assert_mxl_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (csr_addr == ISA_CSR_ADDR) |-> csr_rdata[XLEN-1 -: 2] == width_code(XLEN));
        end else begin : g_off
            assert_absent_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
                csr_rdata == '0 && ext_active == '0);
        end
    endgenerate
endmodule

bind isa_ext_reg isa_ext_reg_chk #(
    .XLEN(XLEN), .REG_PRESENT(REG_PRESENT), .WR_MASK(WR_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .ext_active(ext_active),
    .ialign32(ialign32), .ext_q(ext_q)
);

// File: tb/isa_ext_reg_test.sv
module isa_ext_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = 12'h301;
    logic        csr_we = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic [31:0] rdata;
    logic [25:0] active;
    logic        align;
    logic [63:0] rdata64;
    logic [25:0] active64;
    logic        align64;
    logic [31:0] rdata_off;
    logic [25:0] active_off;
    logic        align_off;
    int          n_tests = 0;
    int          n_fail  = 0;

    always #5 clk = ~clk;

    isa_ext_reg #(.XLEN(32)) uut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata[31:0]), .csr_rdata(rdata), .ext_active(active),
        .ialign32(align));

    isa_ext_reg #(.XLEN(64)) uut64 (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(rdata64), .ext_active(active64),
        .ialign32(align64));

    isa_ext_reg #(.XLEN(32), .REG_PRESENT(1'b0)) uut_off (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata[31:0]), .csr_rdata(rdata_off), .ext_active(active_off),
        .ialign32(align_off));

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic we);
        @(negedge clk);
        csr_addr = a; csr_we = we; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0; csr_addr = 12'h301;
        #1;
    endtask

    task automatic t_reset;
        check("R1 reset read", 64'(rdata), 64'h4015116D);
        check("R10 reset active", 64'(active), 64'h15116D);
        check("R10 reset align", 64'(align), 64'h0);
        check("R2 width code 64", rdata64, 64'h8000_0000_0015_116D);
    endtask

    task automatic t_clear_am;
        wr(12'h301, 64'h0015012C, 1'b1);
        check("R4 G drops with A,M", 64'(rdata), 64'h4015012C);
        check("R10 active after clear", 64'(active), 64'h15012C);
    endtask

    task automatic t_zeros_ones;
        wr(12'h301, 64'h0, 1'b1);
        check("R3 zeros keep I,S", 64'(rdata), 64'h40040100);
        check("R10 align on C clear", 64'(align), 64'h1);
        wr(12'h301, {64{1'b1}}, 1'b1);
        check("R3 ones no B,H,V R2 R4", 64'(rdata), 64'h4015116D);
        check("R10 align on C set", 64'(align), 64'h0);
    endtask

    task automatic t_fd_rule;
        wr(12'h301, 64'h0015110C, 1'b1);
        check("R5 F kept, A cleared", 64'(rdata), 64'h4015112C);
        wr(12'h301, 64'h00141104, 1'b1);
        check("R5 F,D,Q cleared together", 64'(rdata), 64'h40141104);
    endtask

    task automatic t_q_rule;
        wr(12'h301, 64'h00151104, 1'b1);
        check("R6 Q rejected F,D clear", 64'(rdata), 64'h40141104);
        wr(12'h301, 64'h00151124, 1'b1);
        check("R6 Q rejected D clear, F set", 64'(rdata), 64'h40141124);
        wr(12'h301, 64'h0015112C, 1'b1);
        check("R6 Q accepted with F,D", 64'(rdata), 64'h4015112C);
    endtask

    task automatic t_gating;
        wr(12'h301, 64'h0, 1'b0);
        check("R7 we low ignored", 64'(rdata), 64'h4015112C);
        @(negedge clk);
        csr_addr = 12'h300; csr_we = 1'b1; csr_wdata = 64'h0;
        #1;
        check("R8 other addr reads zero", 64'(rdata), 64'h0);
        @(negedge clk);
        csr_we = 1'b0; csr_addr = 12'h301;
        #1;
        check("R7 other addr write ignored", 64'(rdata), 64'h4015112C);
    endtask

    task automatic t_absent;
        check("R9 absent read", 64'(rdata_off), 64'h0);
        check("R9 absent active", 64'(active_off), 64'h0);
        wr(12'h301, {64{1'b1}}, 1'b1);
        check("R9 absent after write", 64'(rdata_off), 64'h0);
        check("R9 absent active after write", 64'(active_off), 64'h0);
    endtask

    initial begin
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_clear_am();
        t_zeros_ones();
        t_fd_rule();
        t_q_rule();
        t_gating();
        t_absent();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule